// File: doc/BRIEF.md
# Multi-Cycle Housekeeping Microcontroller

This block is a small sequencer core for on-chip supervision jobs that are awkward to write as a dedicated state machine but do not justify a full processor. It is not pipelined. Each instruction moves through a fixed series of clock cycles, so the read latency of the instruction store is absorbed without any stall logic. The core has a program counter and sixteen 16-bit general registers. It emits results on a single value port that carries a one-cycle valid strobe.

Instructions are stored as decoded records, not as compact opcodes. Each record is a kind tag plus the fields that kind uses: a destination, two source registers, a comparison selector and a 16-bit immediate. The core fetches them from an external synchronous-read instruction store, one word per address. The store returns data one cycle after the address is presented.

The kinds are no-op, load-immediate, register add, add-immediate, relative jump, compare-and-branch, output and unsigned divide. Divide hands its operands to a serial divider that produces one quotient bit per cycle. The core holds still until the divider reports completion.

Top module: `mgmt_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all sixteen registers to 0 and deasserts `out_valid`. A program whose first instruction outputs any register therefore emits 0.
- R2: Instruction words are 33 bits wide, with these fields: kind [32:30], dest [29:26], opa [25:22], opb [21:18], cmp [17:16], imm [15:0]. The kind codes are 0 no-op, 1 load-immediate, 2 add, 3 add-immediate, 4 jump, 5 branch, 6 output and 7 divide. `imem_addr` always equals the program counter, and the store answers one cycle after it sees the address.
- R3: Every instruction other than divide takes exactly 4 clock cycles. The program counter changes at most once in any two consecutive cycles.
- R4: Load-immediate writes imm to dest. Add writes opa+opb to dest. Add-immediate writes opa+imm to dest. All sums wrap modulo 2^16.
- R5: Jump adds the signed imm to the address of the jump itself, modulo the address width. An offset of 0 repeats the jump forever (halt), and an offset of -3 returns three instructions back.
- R6: Branch compares registers opa and opb as unsigned values. cmp 0 tests less-than, cmp 1 tests greater-than, cmp 2 tests equality and cmp 3 never holds. When the test holds, the target is the branch address plus the signed imm; otherwise execution continues at the next address.
- R7: Output raises `out_valid` for exactly one cycle with `out_data` equal to register opa. No other kind raises `out_valid`.
- R8: Divide writes the unsigned quotient opa/opb to dest. The core stalls while the serial divider iterates: the program counter stays put and no output is produced. The instruction takes at least DATA_W+4 cycles.
- R9: Divide by zero writes 0xFFFF and completes without hanging.
- R10: A no-op changes no register and produces no output. It only advances the program counter by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction store read address (program counter) |
| imem_rdata | input | 33 | Instruction record, valid one cycle after the address |
| out_valid | output | 1 | One-cycle strobe for an output instruction |
| out_data | output | 16 | Register value emitted by an output instruction |

## Verification
The hardest situation to reach from the ports is a divide whose operands come from earlier arithmetic, where the stall must be timed exactly and the quotient must land before a dependent output or branch reads it. Divide by zero adds a further case, because the core must leave the stall on its own. The stimulus reaches these cases in two ways. Random straight-line programs draw their register operands from a narrow set, so divides, adds and compares often depend on one another. Directed programs then measure the gap between output strobes around a divide, drive a divisor of zero, and run a counting loop that exits through a greater-than branch.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int DATA_W = 16;
    localparam int RSEL_W = 4;
    localparam int NREG   = 1 << RSEL_W;
    localparam int IMM_W  = 16;
    localparam int INSN_W = 3 + 3 * RSEL_W + 2 + IMM_W;

    typedef enum logic [2:0] {
        K_NOP  = 3'd0,
        K_SET  = 3'd1,
        K_ADD  = 3'd2,
        K_ADDI = 3'd3,
        K_JMP  = 3'd4,
        K_BR   = 3'd5,
        K_OUT  = 3'd6,
        K_DIV  = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        C_LT    = 2'd0,
        C_GT    = 2'd1,
        C_EQ    = 2'd2,
        C_NEVER = 2'd3
    } cmp_e;

    typedef struct packed {
        kind_e              kind;
        logic [RSEL_W-1:0]  dest;
        logic [RSEL_W-1:0]  opa;
        logic [RSEL_W-1:0]  opb;
        cmp_e               cmp;
        logic [IMM_W-1:0]   imm;
    } insn_t;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC,
        S_DIVW,
        S_WB
    } phase_e;

    function automatic logic cmp_holds(cmp_e c, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
        case (c)
            C_LT:    return a < b;
            C_GT:    return a > b;
            C_EQ:    return a == b;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RSEL_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RSEL_W-1:0] raddr_a,
    input  logic [RSEL_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && waddr == RSEL_W'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mgmt_serial_div.sv
module mgmt_serial_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic          fits;
    logic [W-1:0]  rem_nx;

    // restoring step: divisor 0 always fits, so every quotient bit becomes 1
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        fits    = shifted >= {1'b0, den_q};
        rem_nx  = fits ? W'(shifted - {1'b0, den_q}) : W'(shifted);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= dividend;
                den_q <= divisor;
                cnt_q <= '0;
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= rem_nx;
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

endmodule

// File: rtl/mgmt_exec.sv
module mgmt_exec
    import mgmt_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  kind_e             kind,
    input  cmp_e              cmp,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [PC_W-1:0]   pc,
    output logic [DATA_W-1:0] result,
    output logic              wr,
    output logic              is_out,
    output logic              is_div,
    output logic [PC_W-1:0]   next_pc
);

    logic taken;

    always_comb begin
        result = '0;
        wr     = 1'b0;
        is_out = 1'b0;
        is_div = 1'b0;
        taken  = 1'b0;
        case (kind)
            K_SET:  begin result = imm;     wr = 1'b1; end
            K_ADD:  begin result = a + b;   wr = 1'b1; end
            K_ADDI: begin result = a + imm; wr = 1'b1; end
            K_JMP:  taken = 1'b1;
            K_BR:   taken = cmp_holds(cmp, a, b);
            K_OUT:  begin result = a;       is_out = 1'b1; end
            K_DIV:  begin is_div = 1'b1;    wr = 1'b1; end
            default: ;
        endcase
        // two's complement truncation keeps negative offsets correct
        next_pc = taken ? pc + imm[PC_W-1:0] : pc + 1'b1;
    end

endmodule

// File: rtl/mgmt_core.sv
module mgmt_core
    import mgmt_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    output logic [PC_W-1:0]             imem_addr,
    input  logic [mgmt_pkg::INSN_W-1:0] imem_rdata,
    output logic                        out_valid,
    output logic [mgmt_pkg::DATA_W-1:0] out_data
);

    phase_e            phase;
    logic [PC_W-1:0]   pc;
    insn_t             ir;
    logic [DATA_W-1:0] res_q;
    logic              wr_q;
    logic              out_q;
    logic [PC_W-1:0]   npc_q;

    logic [DATA_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_b;
    logic [DATA_W-1:0] ex_result;
    logic              ex_wr;
    logic              ex_out;
    logic              ex_div;
    logic [PC_W-1:0]   ex_npc;
    logic              rf_we;
    logic              div_start;
    logic              div_busy;
    logic              div_done;
    logic [DATA_W-1:0] div_quo;

    assign imem_addr = pc;
    assign rf_we     = (phase == S_WB) && wr_q;
    assign div_start = (phase == S_EXEC) && ex_div;

    mgmt_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (ir.dest),
        .wdata   (res_q),
        .raddr_a (ir.opa),
        .raddr_b (ir.opb),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    mgmt_exec #(.PC_W(PC_W)) u_exec (
        .kind    (ir.kind),
        .cmp     (ir.cmp),
        .imm     (ir.imm),
        .a       (rd_a),
        .b       (rd_b),
        .pc      (pc),
        .result  (ex_result),
        .wr      (ex_wr),
        .is_out  (ex_out),
        .is_div  (ex_div),
        .next_pc (ex_npc)
    );

    mgmt_serial_div #(.W(DATA_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (rd_a),
        .divisor  (rd_b),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= S_FETCH;
            pc        <= '0;
            ir        <= '0;
            res_q     <= '0;
            wr_q      <= 1'b0;
            out_q     <= 1'b0;
            npc_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (phase)
                S_FETCH: phase <= S_DECODE;
                S_DECODE: begin
                    ir    <= insn_t'(imem_rdata);
                    phase <= S_EXEC;
                end
                S_EXEC: begin
                    res_q <= ex_result;
                    wr_q  <= ex_wr;
                    out_q <= ex_out;
                    npc_q <= ex_npc;
                    phase <= ex_div ? S_DIVW : S_WB;
                end
                S_DIVW: begin
                    if (div_done) begin
                        res_q <= div_quo;
                        phase <= S_WB;
                    end
                end
                S_WB: begin
                    pc <= npc_q;
                    if (out_q) begin
                        out_valid <= 1'b1;
                        out_data  <= res_q;
                    end
                    phase <= S_FETCH;
                end
                default: phase <= S_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/mgmt_core_chk.sv
module mgmt_core_chk #(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] imem_addr,
    input logic            out_valid,
    input logic            div_busy
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: after a reset edge the address and strobe are cleared
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_clears: assert (!out_valid && imem_addr == '0)
                else $error("R1 reset state wrong");
        end
    end

    // R7: strobe lasts one cycle
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3: program counter never moves on two adjacent cycles
    a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(imem_addr) |=> $stable(imem_addr));

    // R8: core frozen while the divider iterates
    a_r8_div_stall_pc: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> $stable(imem_addr));

    a_r8_div_stall_out: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> !out_valid);

endmodule

bind mgmt_core mgmt_core_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .out_valid (out_valid),
    .div_busy  (div_busy)
);

// File: tb/mgmt_core_tb.sv
`timescale 1ns/1ps
module mgmt_core_tb;

    localparam int PC_W  = 8;
    localparam int DW    = 16;
    localparam int IW    = 33;
    localparam int NPROG = 1 << PC_W;
    localparam int CAP   = 8192;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] imem_addr;
    logic [IW-1:0]   imem_rdata = '0;
    logic            out_valid;
    logic [DW-1:0]   out_data;

    logic [IW-1:0] prog [NPROG];
    int            cyc = 0;
    int            got_n = 0;
    logic [DW-1:0] got_v [CAP];
    int            got_t [CAP];
    logic [DW-1:0] exp_v [CAP];
    int            exp_n;
    int            budget;
    int            n_chk = 0;
    int            n_bad = 0;

    always #2 clk = ~clk;

    mgmt_core #(.PC_W(PC_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    // R2: synchronous store, one cycle of read latency
    always @(posedge clk) imem_rdata <= prog[imem_addr];
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid && got_n < CAP) begin
            got_v[got_n] = out_data;
            got_t[got_n] = cyc;
            got_n = got_n + 1;
        end
    end

    initial begin
        #(4 * 200000);
        n_bad = n_bad + 1;
        $display("FAIL watchdog: act=hung exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    function automatic logic [IW-1:0] mk(logic [2:0] k, logic [3:0] d, logic [3:0] a,
                                         logic [3:0] b, logic [1:0] c, logic [15:0] imm);
        return {k, d, a, b, c, imm};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < NPROG; i++) prog[i] = mk(3'd4, 0, 0, 0, 0, 16'd0);
    endtask

    // instruction-level model built from the requirements
    task automatic model();
        logic [DW-1:0]   r [16];
        logic [PC_W-1:0] pc;
        logic [IW-1:0]   w;
        logic [2:0]      k;
        logic [DW-1:0]   a, b, imm;
        bit              tk;
        for (int i = 0; i < 16; i++) r[i] = '0;
        pc = '0; exp_n = 0; budget = 0;
        for (int s = 0; s < 3000; s++) begin
            w   = prog[pc];
            k   = w[32:30];
            a   = r[w[25:22]];
            b   = r[w[21:18]];
            imm = w[15:0];
            tk  = 1'b0;
            budget = budget + ((k == 3'd7) ? DW + 8 : 4);
            case (k)
                3'd1: r[w[29:26]] = imm;
                3'd2: r[w[29:26]] = a + b;
                3'd3: r[w[29:26]] = a + imm;
                3'd4: tk = 1'b1;
                3'd5: tk = (w[17:16] == 2'd0) ? (a < b) :
                           (w[17:16] == 2'd1) ? (a > b) :
                           (w[17:16] == 2'd2) ? (a == b) : 1'b0;
                3'd6: begin exp_v[exp_n] = a; exp_n = exp_n + 1; end
                3'd7: r[w[29:26]] = (b == 0) ? 16'hFFFF : a / b;
                default: ;
            endcase
            if (k == 3'd4 && imm == 0) break;
            pc = tk ? pc + imm[PC_W-1:0] : pc + 1'b1;
        end
    endtask

    task automatic run(input string req, output int base);
        model();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 strobe low in reset", out_valid, 0);
        chk(imem_addr == '0, "R1 pc zero in reset", imem_addr, 0);
        base = got_n;
        rst = 1'b0;
        repeat (budget + 12) @(posedge clk);
        @(negedge clk);
        chk(got_n - base == exp_n, {req, " output count"}, got_n - base, exp_n);
        for (int i = 0; i < exp_n && base + i < CAP; i++)
            chk(got_v[base + i] == exp_v[i], req, got_v[base + i], exp_v[i]);
    endtask

    initial begin
        int b;
        void'($urandom(32'd2718));

        // R1: registers start at zero
        clear_prog();
        prog[0] = mk(6, 0, 5, 0, 0, 0);
        prog[1] = mk(6, 0, 15, 0, 0, 0);
        run("R1 register reset", b);

        // R4: wrapping arithmetic
        clear_prog();
        prog[0] = mk(1, 1, 0, 0, 0, 16'hFFFF);
        prog[1] = mk(3, 2, 1, 0, 0, 16'd2);
        prog[2] = mk(6, 0, 2, 0, 0, 0);
        prog[3] = mk(2, 3, 1, 1, 0, 0);
        prog[4] = mk(6, 0, 3, 0, 0, 0);
        run("R4 wrap", b);
        chk(got_v[b] == 16'h0001, "R4 addi wrap", got_v[b], 16'h0001);
        chk(got_v[b+1] == 16'hFFFE, "R4 add wrap", got_v[b+1], 16'hFFFE);

        // R6: each comparison code
        clear_prog();
        prog[0] = mk(1, 1, 0, 0, 0, 16'd5);
        prog[1] = mk(1, 2, 0, 0, 0, 16'd9);
        prog[2] = mk(5, 0, 1, 2, 0, 16'd2);
        prog[3] = mk(6, 0, 1, 0, 0, 0);
        prog[4] = mk(5, 0, 1, 2, 1, 16'd2);
        prog[5] = mk(6, 0, 2, 0, 0, 0);
        prog[6] = mk(5, 0, 1, 1, 2, 16'd2);
        prog[7] = mk(6, 0, 1, 0, 0, 0);
        prog[8] = mk(5, 0, 1, 2, 3, 16'd2);
        prog[9] = mk(6, 0, 1, 0, 0, 0);
        run("R6 compare", b);
        chk(exp_n == 2 && got_v[b] == 16'd9 && got_v[b+1] == 16'd5, "R6 branch path",
            {got_v[b], got_v[b+1]}, {16'd9, 16'd5});

        // R3 R8 R9 R10: timing around no-op and divide by zero
        clear_prog();
        prog[0] = mk(1, 1, 0, 0, 0, 16'd7);
        prog[1] = mk(6, 0, 1, 0, 0, 0);
        prog[2] = mk(6, 0, 1, 0, 0, 0);
        prog[3] = mk(0, 1, 1, 1, 0, 16'h1234);
        prog[4] = mk(6, 0, 1, 0, 0, 0);
        prog[5] = mk(7, 3, 1, 2, 0, 0);
        prog[6] = mk(6, 0, 3, 0, 0, 0);
        prog[7] = mk(1, 4, 0, 0, 0, 16'd100);
        prog[8] = mk(1, 5, 0, 0, 0, 16'd7);
        prog[9] = mk(7, 6, 4, 5, 0, 0);
        prog[10] = mk(6, 0, 6, 0, 0, 0);
        run("R8 divide", b);
        chk(got_t[b+1] - got_t[b] == 4, "R3 four-cycle instruction", got_t[b+1] - got_t[b], 4);
        chk(got_t[b+2] - got_t[b+1] == 8, "R10 nop costs one slot", got_t[b+2] - got_t[b+1], 8);
        chk(got_v[b+2] == 16'd7, "R10 nop leaves registers", got_v[b+2], 7);
        chk(got_t[b+3] - got_t[b+2] >= 4 + DW + 4, "R8 divide stalls",
            got_t[b+3] - got_t[b+2], 4 + DW + 4);
        chk(got_v[b+3] == 16'hFFFF, "R9 divide by zero", got_v[b+3], 16'hFFFF);
        chk(got_v[b+4] == 16'd14, "R8 quotient", got_v[b+4], 14);

        // R5: counting loop with backward jump, exits through greater-than
        clear_prog();
        prog[0] = mk(1, 0, 0, 0, 0, 16'd0);
        prog[1] = mk(1, 2, 0, 0, 0, 16'd100);
        prog[2] = mk(3, 0, 0, 0, 0, 16'd1);
        prog[3] = mk(6, 0, 0, 0, 0, 0);
        prog[4] = mk(5, 0, 0, 2, 1, 16'd2);
        prog[5] = mk(4, 0, 0, 0, 0, 16'hFFFD);
        run("R5 loop", b);
        chk(exp_n == 101, "R5 loop length", exp_n, 101);

        // random programs with forward branches and dependent divides (R2 R4 R6 R7 R8)
        for (int p = 0; p < 30; p++) begin
            clear_prog();
            for (int i = 0; i < 24; i++) begin
                logic [2:0]  k;
                logic [15:0] imm;
                k = 3'($urandom_range(0, 7));
                if (k == 3'd4) k = 3'd6;
                imm = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 20));
                if (k == 3'd5) imm = 16'($urandom_range(1, 3));
                prog[i] = mk(k, 4'($urandom_range(0, 5)), 4'($urandom_range(0, 5)),
                             4'($urandom_range(0, 5)), 2'($urandom_range(0, 3)), imm);
            end
            prog[24] = mk(6, 0, 4'($urandom_range(0, 5)), 0, 0, 0);
            run("R7 random program", b);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule